// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Request

This unit keeps the two sticky status flags of a synchronous serial controller and turns them into a single interrupt request. One flag reports a write collision: software wrote the transmit data register while a shift was still running. The other flag reports that a reception has finished. Both flags live in one status register on the CPU register bus. A second register holds one interrupt enable bit per flag.

The unit sees four signals from the rest of the controller, which are modelled here as plain inputs. They are the transmit-register write strobe, a pulse for each read of the receive data register, the transfer-busy level and the strobe for the last sample edge. Software can clear a flag by writing zero to it, with a byte mask or a single-bit mask. Software can also clear a flag without a write: it reads the status register and then performs the data-register access that belongs to that flag. The unit remembers each such read in an internal "armed" bit per flag.

Top module: `sspi_flag_irq`

## Requirements
- R1: The status register is at address F8h. Bit 0 is the transfer-complete flag and bit 1 is the write-collision flag. Bits 7..2 read as 0. The enable register is at address F9h: bit 0 enables transfer-complete and bit 1 enables write-collision. Reads of any other address return 0. After reset, both flags, both enables and the interrupt output are 0.
- R2: The write-collision flag becomes 1 in the cycle after the transmit write strobe falls, if busy was high in any cycle while the strobe was high. If busy stayed low for the whole strobe, the flag does not set.
- R3: The transfer-complete flag becomes 1 one cycle after a last-sample strobe.
- R4: A write to the status register clears each flag whose mask bit is 1 and whose data bit is 0. A flag whose mask bit is 0 keeps its value.
- R5: Writing 1 to a flag bit has no effect. A flag is set only by its hardware event.
- R6: The write-collision flag clears when a status read that shows it as 1 is later followed by the fall of a transmit write strobe. A strobe with no such read before it leaves the flag set.
- R7: The transfer-complete flag clears when a status read that shows it as 1 is later followed by a receive-read pulse. A receive read with no such read before it, or after a read that showed the flag as 0, leaves the flag set.
- R8: Any clear of a flag also discards its armed state. After a software clear and a new set event, the data-register access alone does not clear the flag.
- R9: When a set event and a clear of the same flag happen in the same cycle, the flag ends at 1.
- R10: The interrupt output is registered. It is 1 in the cycle after any enabled flag is 1, and 0 in the cycle after no enabled flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register bus write |
| reg_rd_en | input | 1 | Register bus read |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 8 | Register write data |
| reg_wmask | input | 8 | Per-bit write mask (all ones for a byte write, a single bit for a bit write) |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_wr_i | input | 1 | Transmit data register write strobe |
| rx_rd_i | input | 1 | Receive data register read pulse |
| busy_i | input | 1 | Transfer in progress |
| last_sample_i | input | 1 | Last sample edge of a reception |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker examines every cycle for several things. Each flag must rise one cycle after its hardware event and only after that event. A software zero-write with no competing set must clear the flag. Reserved status bits must read as zero. The interrupt must follow the enabled flags with a one-cycle lag. Some behaviours show only across sequences of operations, and the directed scenarios cover them. These are the two-step hardware clears, including the case where a read showed the flag as 0. They also include the loss of the armed state after a software clear, same-cycle races between set and clear, and the fact that one-writes and reserved-bit writes leave the flags untouched.

// File: rtl/sspi_flag_pkg.sv
package sspi_flag_pkg;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned TC_IDX    = 0;
  localparam int unsigned WC_IDX    = 1;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/sspi_strobe_edge.sv
module sspi_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic busy_i,
  output logic fall_o,
  output logic coll_o
);
  logic strobe_q, strobe_d;
  logic seen_q, seen_d;

  assign fall_o = strobe_q & ~strobe_i;
  assign coll_o = fall_o & seen_q;

  always_comb begin
    strobe_d = strobe_i;
    seen_d   = seen_q;
    if (fall_o)                 seen_d = 1'b0;
    else if (strobe_i & busy_i) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      seen_q   <= seen_d;
    end
  end
endmodule

// File: rtl/sspi_sticky_flag.sv
module sspi_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic sw_clr_i,
  input  logic stat_rd_i,
  input  logic access_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic clr;

  assign clr    = sw_clr_i | (access_i & armed_q);
  assign flag_o = flag_q;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (set_i)    flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    if (clr)                       armed_d = 1'b0;
    else if (stat_rd_i && flag_q)  armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/sspi_flag_irq.sv
module sspi_flag_irq
  import sspi_flag_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hF8,
  parameter logic [ADDR_W-1:0] IEN_ADDR  = 8'hF9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_wmask,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_wr_i,
  input  logic              rx_rd_i,
  input  logic              busy_i,
  input  logic              last_sample_i,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_FLAGS;

  logic      stat_hit, ien_hit, stat_wr, stat_rd, ien_wr;
  logic      tx_fall, coll_evt;
  flag_vec_t set_vec, acc_vec, sw_clr_vec, flags;
  flag_vec_t en_q, en_d;
  logic      irq_q, irq_d;

  assign stat_hit = (reg_addr == STAT_ADDR);
  assign ien_hit  = (reg_addr == IEN_ADDR);
  assign stat_wr  = reg_wr_en & stat_hit;
  assign stat_rd  = reg_rd_en & stat_hit;
  assign ien_wr   = reg_wr_en & ien_hit;

  sspi_strobe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (tx_wr_i),
    .busy_i   (busy_i),
    .fall_o   (tx_fall),
    .coll_o   (coll_evt)
  );

  always_comb begin
    set_vec         = '0;
    acc_vec         = '0;
    set_vec[TC_IDX] = last_sample_i;
    set_vec[WC_IDX] = coll_evt;
    acc_vec[TC_IDX] = rx_rd_i;
    acc_vec[WC_IDX] = tx_fall;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign sw_clr_vec[i] = stat_wr & reg_wmask[i] & ~reg_wdata[i];
    sspi_sticky_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_vec[i]),
      .sw_clr_i  (sw_clr_vec[i]),
      .stat_rd_i (stat_rd),
      .access_i  (acc_vec[i]),
      .flag_o    (flags[i])
    );
  end

  always_comb begin
    en_d = en_q;
    if (ien_wr)
      en_d = (en_q & ~reg_wmask[NUM_FLAGS-1:0]) |
             (reg_wdata[NUM_FLAGS-1:0] & reg_wmask[NUM_FLAGS-1:0]);
    irq_d = |(flags & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (stat_hit)     reg_rdata = {{PAD_W{1'b0}}, flags};
    else if (ien_hit) reg_rdata = {{PAD_W{1'b0}}, en_q};
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sspi_flag_irq_chk.sv
module sspi_flag_irq_chk
  import sspi_flag_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       stat_hit,
  input logic [7:0] reg_rdata,
  input logic       last_sample_i,
  input logic       coll_evt,
  input flag_vec_t  set_vec,
  input flag_vec_t  sw_clr_vec,
  input flag_vec_t  flags,
  input flag_vec_t  en_q,
  input logic       irq_o
);
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hit |-> (reg_rdata[7:2] == 6'd0));

  assert_wcol_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> flags[WC_IDX]);

  assert_tc_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_sample_i |=> flags[TC_IDX]);

  assert_tc_swclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_vec[TC_IDX] && !set_vec[TC_IDX]) |=> !flags[TC_IDX]);

  assert_wc_swclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_vec[WC_IDX] && !set_vec[WC_IDX]) |=> !flags[WC_IDX]);

  assert_tc_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[TC_IDX]) |-> $past(last_sample_i));

  assert_wc_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[WC_IDX]) |-> $past(coll_evt));

  assert_irq_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en_q) != '0) |=> irq_o);

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en_q) == '0) |=> !irq_o);
endmodule

bind sspi_flag_irq sspi_flag_irq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stat_hit      (stat_hit),
  .reg_rdata     (reg_rdata),
  .last_sample_i (last_sample_i),
  .coll_evt      (coll_evt),
  .set_vec       (set_vec),
  .sw_clr_vec    (sw_clr_vec),
  .flags         (flags),
  .en_q          (en_q),
  .irq_o         (irq_o)
);

// File: tb/sspi_flag_irq_tb.sv
`timescale 1ns/1ps
module sspi_flag_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_wmask = 8'h00;
  logic [7:0] reg_rdata;
  logic       tx_wr_i = 1'b0, rx_rd_i = 1'b0, busy_i = 1'b0, last_sample_i = 1'b0;
  logic       irq_o;
  int         checks = 0, errors = 0;

  localparam logic [7:0] STAT = 8'hF8;
  localparam logic [7:0] IEN  = 8'hF9;

  always #2 clk = ~clk;

  sspi_flag_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
    .reg_rdata(reg_rdata), .tx_wr_i(tx_wr_i), .rx_rd_i(rx_rd_i),
    .busy_i(busy_i), .last_sample_i(last_sample_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input logic [7:0] m);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wmask = 8'h00;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic last_pulse();
    last_sample_i = 1'b1;
    @(negedge clk);
    last_sample_i = 1'b0;
  endtask

  task automatic rx_pulse();
    rx_rd_i = 1'b1;
    @(negedge clk);
    rx_rd_i = 1'b0;
  endtask

  task automatic tx_write(input logic busy);
    tx_wr_i = 1'b1; busy_i = busy;
    @(negedge clk);
    @(negedge clk);
    tx_wr_i = 1'b0; busy_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_map();
    logic [7:0] d;
    do_reset();
    bus_rd(STAT, d); check("R1 status reset", d, 8'h00);
    bus_rd(IEN, d);  check("R1 enable reset", d, 8'h00);
    check("R1 irq reset", {7'd0, irq_o}, 8'h00);
    last_pulse();
    tx_write(1'b1);
    bus_wr(STAT, 8'hFF, 8'hFC);
    bus_rd(STAT, d); check("R1 bit positions, reserved read 0", d, 8'h03);
    bus_wr(IEN, 8'hFF, 8'hFF);
    bus_rd(IEN, d);  check("R1 enable bits only", d, 8'h03);
    bus_rd(8'h10, d); check("R1 other address", d, 8'h00);
  endtask

  task automatic t_wcol_set();
    logic [7:0] d;
    do_reset();
    tx_write(1'b0);
    bus_rd(STAT, d); check("R2 idle write no collision", d, 8'h00);
    tx_wr_i = 1'b1; busy_i = 1'b1;
    @(negedge clk);
    busy_i = 1'b0;
    @(negedge clk);
    tx_wr_i = 1'b0;
    #1 check("R2 not yet set before strobe falls", reg_rdata, 8'h00);
    @(negedge clk);
    bus_rd(STAT, d); check("R2 collision after strobe fall", d, 8'h02);
  endtask

  task automatic t_tc_set_swclr();
    logic [7:0] d;
    do_reset();
    reg_addr = STAT;
    last_sample_i = 1'b1;
    #1 check("R3 not set same cycle", reg_rdata, 8'h00);
    @(negedge clk);
    last_sample_i = 1'b0;
    #1 check("R3 set next cycle", reg_rdata, 8'h01);
    tx_write(1'b1);
    bus_wr(STAT, 8'h00, 8'h02);
    bus_rd(STAT, d); check("R4 bit write clears only masked flag", d, 8'h01);
    bus_wr(STAT, 8'h03, 8'hFF);
    bus_rd(STAT, d); check("R5 writing ones no effect", d, 8'h01);
    bus_wr(STAT, 8'h00, 8'hFF);
    bus_rd(STAT, d); check("R4 byte write zero clears", d, 8'h00);
  endtask

  task automatic t_wcol_hwclr();
    logic [7:0] d;
    do_reset();
    tx_write(1'b1);
    tx_write(1'b0);
    bus_rd(STAT, d); check("R6 tx write without prior read keeps flag", d, 8'h02);
    tx_write(1'b0);
    bus_rd(STAT, d); check("R6 read then tx write clears", d, 8'h00);
  endtask

  task automatic t_tc_hwclr();
    logic [7:0] d;
    do_reset();
    last_pulse();
    rx_pulse();
    bus_rd(STAT, d); check("R7 rx read without prior status read keeps", d, 8'h01);
    rx_pulse();
    bus_rd(STAT, d); check("R7 status read then rx read clears", d, 8'h00);
    last_pulse();
    rx_pulse();
    bus_rd(STAT, d); check("R7 earlier read showing 0 does not arm", d, 8'h01);
  endtask

  task automatic t_arm_drop();
    logic [7:0] d;
    do_reset();
    last_pulse();
    bus_rd(STAT, d);
    bus_wr(STAT, 8'h00, 8'h01);
    last_pulse();
    rx_pulse();
    reg_addr = STAT;
    #1 check("R8 armed discarded by software clear", reg_rdata, 8'h01);
  endtask

  task automatic t_race();
    logic [7:0] d;
    do_reset();
    last_pulse();
    bus_rd(STAT, d);
    rx_rd_i = 1'b1; last_sample_i = 1'b1;
    @(negedge clk);
    rx_rd_i = 1'b0; last_sample_i = 1'b0;
    reg_addr = STAT;
    #1 check("R9 set beats hardware clear", reg_rdata, 8'h01);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = STAT; reg_wdata = 8'h00; reg_wmask = 8'hFF;
    last_sample_i = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; last_sample_i = 1'b0;
    #1 check("R9 set beats software clear", reg_rdata, 8'h01);
    @(negedge clk);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    do_reset();
    last_pulse();
    @(negedge clk);
    check("R10 disabled flag no irq", {7'd0, irq_o}, 8'h00);
    bus_wr(IEN, 8'h02, 8'hFF);
    @(negedge clk);
    check("R10 other enable no irq", {7'd0, irq_o}, 8'h00);
    bus_wr(IEN, 8'h01, 8'hFF);
    check("R10 irq one cycle late", {7'd0, irq_o}, 8'h00);
    @(negedge clk);
    check("R10 irq asserted", {7'd0, irq_o}, 8'h01);
    bus_wr(STAT, 8'h00, 8'h01);
    check("R10 irq holds one cycle after clear", {7'd0, irq_o}, 8'h01);
    @(negedge clk);
    check("R10 irq deasserted", {7'd0, irq_o}, 8'h00);
    bus_rd(STAT, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_map();
    t_wcol_set();
    t_tc_set_swclr();
    t_wcol_hwclr();
    t_tc_hwclr();
    t_arm_drop();
    t_race();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule